// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with APB Register Port

The block is a watchdog timer that software reaches through an APB slave port. A 32-bit down-counter steps once on every cycle where the watchdog clock-enable input is high. When the counter first runs out, it raises an interrupt and starts again from the reload value. If software has not cleared that interrupt by the time the counter runs out a second time, the block raises a reset request and freezes the counter. Software keeps the watchdog quiet by writing the clear register before the second expiry. Writing the load register sets a new timeout.

A key-based lock protects every register from stray writes. The lock register is the only one that can still be written while the lock is set. An integration-test mode lets software drive both outputs directly. The parameter `RESTRICTED` selects a reduced variant. In that variant the control register can no longer be written once the interrupt enable is set, and the integration registers do not exist. The block also exposes twelve read-only identification words, set by the parameter `ID_BYTES`.

The control logic is a four-state machine:
- `ST_COUNT`: counting, no interrupt pending.
- `ST_ARMED`: counting, interrupt pending.
- `ST_HALT`: stopped, with both the interrupt and the reset status set.
- `ST_SPENT`: stopped, reset status set, interrupt cleared.

The transitions are:
- expiry: `ST_COUNT`→`ST_ARMED`
- clear: `ST_ARMED`→`ST_COUNT`
- second expiry: `ST_ARMED`→`ST_HALT`
- clear after halt: `ST_HALT`→`ST_SPENT`

`ST_SPENT` is left only by system reset.

Top module: `wdt_apb_guard`

## Requirements
- R1: After reset, the load value and the count are 0xFFFFFFFF, the counter runs, and the control, lock, integration-control, raw-status and both outputs are zero.
- R2: Control (offset 0x008) keeps only bit 0 (interrupt enable) and bit 1 (reset enable). All other bits read back as zero.
- R3: A write to load (0x000) sets the reload value and also loads the count (read at 0x004) with it. In the counting states the counter keeps running.
- R4: The count drops by one on each pclk edge where `wclk_en` is high and the counter is running. It does not change otherwise.
- R5: An enabled step from count 1 to count 0 is an expiry. With no interrupt pending, an expiry sets raw status bit 0 (0x010). The next enabled step reloads the count from the load value, so a load value of L gives a period of L+1 enables.
- R6: An expiry while the interrupt is pending sets the reset status and stops the counter for good. Later load writes still update the load value and the count, but the counter stays stopped, and only system reset clears the reset status. A clear in this condition clears raw status only.
- R7: A write of any value to the clear register (0x00C) clears raw status and loads the count from the load value.
- R8: When integration mode is off, `wdt_irq` = raw status AND control bit 0, and `wdt_rst_req` = reset status AND control bit 1. Masked status (0x014) reads the `wdt_irq` term.
- R9: Writing 0x1ACCE551 to the lock register (0xC00) unlocks the block. Any other value locks it. The lock register reads 1 when locked and 0 when unlocked. While locked, writes to every other offset are ignored.
- R10: When integration control (0xF00) bit 0 is set, `wdt_rst_req` follows integration-output (0xF04) bit 0 and `wdt_irq` follows its bit 1.
- R11: With `RESTRICTED`=1, control writes are ignored once control bit 0 is set. Offsets 0xF00 and 0xF04 read zero and ignore writes.
- R12: Reads of the write-only clear register, of unmapped offsets and of absent offsets return zero. Writes to the count, status or unmapped offsets change nothing. `pready` is always 1 and `pslverr` is always 0.
- R13: The word at offset 0xFD0+4k (k = 0..11) reads byte k of `ID_BYTES`, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| wclk_en | input | 1 | Watchdog count enable, one step per high cycle |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | AW | APB byte address within the window |
| pwdata | input | DW | APB write data |
| prdata | output | DW | APB read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| wdt_irq | output | 1 | Interrupt output |
| wdt_rst_req | output | 1 | Reset request output |

## Verification
A wrong state shows up at the ports one clock edge after the fault, because both outputs and the raw-status read are decoded directly from the state register. For example, an expiry that took the wrong branch makes `wdt_irq` or `wdt_rst_req` differ on the next sample, and a counter that kept running in a halted state moves the count read within one enable. Errors in the reload arithmetic show up as a count that is off by one at the expiry boundary. The bench sweeps small load values and reads the count and status exactly one enable before and one enable after each expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        ST_COUNT = 2'd0,
        ST_ARMED = 2'd1,
        ST_HALT  = 2'd2,
        ST_SPENT = 2'd3
    } wdt_state_e;

    localparam logic [11:0] OFF_LOAD  = 12'h000;
    localparam logic [11:0] OFF_COUNT = 12'h004;
    localparam logic [11:0] OFF_CTRL  = 12'h008;
    localparam logic [11:0] OFF_CLR   = 12'h00C;
    localparam logic [11:0] OFF_RIS   = 12'h010;
    localparam logic [11:0] OFF_MIS   = 12'h014;
    localparam logic [11:0] OFF_LOCK  = 12'hC00;
    localparam logic [11:0] OFF_ITCR  = 12'hF00;
    localparam logic [11:0] OFF_ITOP  = 12'hF04;
    localparam logic [11:0] OFF_ID0   = 12'hFD0;
    localparam int          ID_WORDS  = 12;
    localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter int DW         = 32,
    parameter int AW         = 12,
    parameter bit RESTRICTED = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] load_q,
    output logic [1:0]    ctrl_q,
    output logic          locked_q,
    output logic          itcr_q,
    output logic [1:0]    itop_q,
    output logic          load_wr,
    output logic          clr_wr
);
    logic wr_ok;
    logic ctrl_wr;

    assign wr_ok   = wr_en && (!locked_q || addr == AW'(OFF_LOCK));
    assign load_wr = wr_ok && addr == AW'(OFF_LOAD);
    assign clr_wr  = wr_ok && addr == AW'(OFF_CLR);
    assign ctrl_wr = wr_ok && addr == AW'(OFF_CTRL) && !(RESTRICTED && ctrl_q[0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q   <= '1;
            ctrl_q   <= 2'b00;
            locked_q <= 1'b0;
        end else begin
            if (load_wr) load_q <= wdata;
            if (ctrl_wr) ctrl_q <= wdata[1:0];
            if (wr_en && addr == AW'(OFF_LOCK))
                locked_q <= (wdata != DW'(UNLOCK_KEY));
        end
    end

    generate
        if (RESTRICTED) begin : g_no_itest
            assign itcr_q = 1'b0;
            assign itop_q = 2'b00;
        end else begin : g_itest
            logic       itcr_r;
            logic [1:0] itop_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    itcr_r <= 1'b0;
                    itop_r <= 2'b00;
                end else begin
                    if (wr_ok && addr == AW'(OFF_ITCR)) itcr_r <= wdata[0];
                    if (wr_ok && addr == AW'(OFF_ITOP)) itop_r <= wdata[1:0];
                end
            end
            assign itcr_q = itcr_r;
            assign itop_q = itop_r;
        end
    endgenerate

    // R9: a locked block keeps its load value through a load write
    p_lock_holds_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && wr_en && addr == AW'(OFF_LOAD)) |=> $stable(load_q));

    // R11: restricted control freezes once the interrupt is enabled
    p_ctrl_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (RESTRICTED && ctrl_q[0]) |=> $stable(ctrl_q));
endmodule

// File: rtl/wdt_engine.sv
module wdt_engine
    import wdt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          reload_req,
    input  logic [DW-1:0] reload_val,
    input  logic [DW-1:0] load_q,
    input  logic          clr_req,
    output logic [DW-1:0] count_q,
    output logic          raw_int,
    output logic          rst_stat
);
    wdt_state_e state_q, state_d;
    logic       running;
    logic       expire;

    assign running = (state_q == ST_COUNT) || (state_q == ST_ARMED);
    assign expire  = running && tick && !reload_req && count_q == DW'(1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT: if (expire)  state_d = ST_ARMED;
            ST_ARMED: if (clr_req) state_d = ST_COUNT;
                      else if (expire) state_d = ST_HALT;
            ST_HALT:  if (clr_req) state_d = ST_SPENT;
            ST_SPENT: state_d = ST_SPENT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COUNT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '1;
        else if (reload_req)
            count_q <= reload_val;
        else if (running && tick)
            count_q <= (count_q == '0) ? load_q : count_q - DW'(1);
    end

    always_comb begin
        raw_int  = 1'b0;
        rst_stat = 1'b0;
        unique case (state_q)
            ST_COUNT: ;
            ST_ARMED: raw_int = 1'b1;
            ST_HALT:  begin raw_int = 1'b1; rst_stat = 1'b1; end
            ST_SPENT: rst_stat = 1'b1;
        endcase
    end

    // R5: first expiry arms the interrupt
    p_arm_on_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && expire) |=> raw_int && !rst_stat);

    // R6: a halted counter does not move without a reload write
    p_halt_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !reload_req) |=> $stable(count_q));

    // R6: reset status is sticky
    p_rst_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_stat |=> rst_stat);

    // R7: a clear while armed returns to counting
    p_clear_disarms_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && clr_req) |=> !raw_int);
endmodule

// File: rtl/wdt_readmux.sv
module wdt_readmux
    import wdt_pkg::*;
#(
    parameter int                  DW         = 32,
    parameter int                  AW         = 12,
    parameter bit                  RESTRICTED = 1'b0,
    parameter logic [ID_WORDS*8-1:0] ID_BYTES = '0
) (
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] load_q,
    input  logic [DW-1:0] count_q,
    input  logic [1:0]    ctrl_q,
    input  logic          raw_int,
    input  logic          mis,
    input  logic          locked_q,
    input  logic          itcr_q,
    output logic [DW-1:0] rdata
);
    localparam logic [AW-1:0] ID_LO = AW'(OFF_ID0);
    localparam logic [AW-1:0] ID_HI = AW'(OFF_ID0 + 12'(4 * (ID_WORDS - 1)));

    logic [DW-1:0] id_word [ID_WORDS];
    logic [AW-1:0] id_off;
    logic          id_hit;

    generate
        for (genvar g = 0; g < ID_WORDS; g++) begin : g_id
            assign id_word[g] = DW'(ID_BYTES[g*8 +: 8]);
        end
    endgenerate

    assign id_off = addr - ID_LO;
    assign id_hit = addr >= ID_LO && addr <= ID_HI && addr[1:0] == 2'b00;

    always_comb begin
        rdata = '0;
        if (id_hit) begin
            rdata = id_word[id_off[AW-1:2]];
        end else begin
            case (addr)
                AW'(OFF_LOAD):  rdata = load_q;
                AW'(OFF_COUNT): rdata = count_q;
                AW'(OFF_CTRL):  rdata = DW'(ctrl_q);
                AW'(OFF_RIS):   rdata = DW'(raw_int);
                AW'(OFF_MIS):   rdata = DW'(mis);
                AW'(OFF_LOCK):  rdata = DW'(locked_q);
                AW'(OFF_ITCR):  rdata = RESTRICTED ? '0 : DW'(itcr_q);
                default:        rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdt_apb_guard.sv
module wdt_apb_guard
    import wdt_pkg::*;
#(
    parameter int                    DW         = 32,
    parameter int                    AW         = 12,
    parameter bit                    RESTRICTED = 1'b0,
    parameter logic [ID_WORDS*8-1:0] ID_BYTES   = 96'hB1_05_F0_0D_00_3C_2A_17_00_00_00_06
) (
    input  logic          pclk,
    input  logic          presetn,
    input  logic          wclk_en,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    output logic [DW-1:0] prdata,
    output logic          pready,
    output logic          pslverr,
    output logic          wdt_irq,
    output logic          wdt_rst_req
);
    logic          wr_en;
    logic [DW-1:0] load_q;
    logic [DW-1:0] count_q;
    logic [1:0]    ctrl_q;
    logic          locked_q;
    logic          itcr_q;
    logic [1:0]    itop_q;
    logic          load_wr;
    logic          clr_wr;
    logic          raw_int;
    logic          rst_stat;
    logic          mis;
    logic          reload_req;
    logic [DW-1:0] reload_val;

    assign wr_en      = psel && penable && pwrite;
    assign pready     = 1'b1;
    assign pslverr    = 1'b0;
    assign reload_req = load_wr || clr_wr;
    assign reload_val = load_wr ? pwdata : load_q;
    assign mis        = raw_int && ctrl_q[0];

    wdt_regfile #(.DW(DW), .AW(AW), .RESTRICTED(RESTRICTED)) u_regs (
        .clk(pclk), .rst_n(presetn), .wr_en(wr_en), .addr(paddr), .wdata(pwdata),
        .load_q(load_q), .ctrl_q(ctrl_q), .locked_q(locked_q), .itcr_q(itcr_q),
        .itop_q(itop_q), .load_wr(load_wr), .clr_wr(clr_wr)
    );

    wdt_engine #(.DW(DW)) u_engine (
        .clk(pclk), .rst_n(presetn), .tick(wclk_en), .reload_req(reload_req),
        .reload_val(reload_val), .load_q(load_q), .clr_req(clr_wr),
        .count_q(count_q), .raw_int(raw_int), .rst_stat(rst_stat)
    );

    wdt_readmux #(.DW(DW), .AW(AW), .RESTRICTED(RESTRICTED), .ID_BYTES(ID_BYTES)) u_rd (
        .addr(paddr), .load_q(load_q), .count_q(count_q), .ctrl_q(ctrl_q),
        .raw_int(raw_int), .mis(mis), .locked_q(locked_q), .itcr_q(itcr_q),
        .rdata(prdata)
    );

    always_comb begin
        if (itcr_q) begin
            wdt_irq     = itop_q[1];
            wdt_rst_req = itop_q[0];
        end else begin
            wdt_irq     = mis;
            wdt_rst_req = rst_stat && ctrl_q[1];
        end
    end

    // R8: with the interrupt disabled and no test override, no interrupt
    p_irq_masked_r8: assert property (@(posedge pclk) disable iff (!presetn)
        (!itcr_q && !ctrl_q[0]) |-> !wdt_irq);

    // R8: no reset request without reset status in normal mode
    p_rst_needs_status_r8: assert property (@(posedge pclk) disable iff (!presetn)
        (!itcr_q && !rst_stat) |-> !wdt_rst_req);

    // R12: the bus never stalls and never errors
    p_bus_static_r12: assert property (@(posedge pclk) disable iff (!presetn)
        pready && !pslverr);
endmodule

// File: tb/sim_wdt_apb_guard.sv
`timescale 1ns/1ps
module sim_wdt_apb_guard;
    localparam logic [95:0] ID_TBL = 96'hB1_05_F0_0D_00_3C_2A_17_00_00_00_06;
    localparam logic [31:0] KEY    = 32'h1ACC_E551;

    logic        clk = 1'b0;
    logic        rstn = 1'b0;
    logic        en = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] rd0, rd1;
    logic        rdy0, err0, irq0, rst0;
    logic        rdy1, err1, irq1, rst1;
    int          n_tests = 0;
    int          n_fail = 0;
    logic [31:0] r;

    always #2 clk = ~clk;

    wdt_apb_guard #(.RESTRICTED(1'b0), .ID_BYTES(ID_TBL)) u0 (
        .pclk(clk), .presetn(rstn), .wclk_en(en), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(rd0),
        .pready(rdy0), .pslverr(err0), .wdt_irq(irq0), .wdt_rst_req(rst0));

    wdt_apb_guard #(.RESTRICTED(1'b1), .ID_BYTES(ID_TBL)) u1 (
        .pclk(clk), .presetn(rstn), .wclk_en(en), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(rd1),
        .pready(rdy1), .pslverr(err1), .wdt_irq(irq1), .wdt_rst_req(rst1));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rstn = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rstn = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d0, output logic [31:0] d1);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1;
        d0 = rd0;
        d1 = rd1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic tick(input int n);
        if (n > 0) begin
            @(negedge clk);
            en = 1'b1;
            repeat (n) @(negedge clk);
            en = 1'b0;
        end
    endtask

    function automatic logic [31:0] rd_u0(input logic [31:0] a0);
        return a0;
    endfunction

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] a, b;
        do_reset();

        // R1 reset values
        rd(12'h000, a, b); chk("R1 load", a, 32'hFFFF_FFFF);
        rd(12'h004, a, b); chk("R1 count", a, 32'hFFFF_FFFF);
        rd(12'h008, a, b); chk("R1 ctrl", a, 0);
        rd(12'hC00, a, b); chk("R1 lock", a, 0);
        rd(12'h010, a, b); chk("R1 ris", a, 0);
        rd(12'hF00, a, b); chk("R1 itcr", a, 0);
        chk("R1 outputs", {30'b0, irq0, rst0}, 0);
        tick(3);
        rd(12'h004, a, b); chk("R1 running", a, 32'hFFFF_FFFC);

        // R2 control mask; R11 restricted freeze
        wr(12'h008, 32'hFFFF_FFFF);
        rd(12'h008, a, b); chk("R2 ctrl mask", a, 3); chk("R11 ctrl set", b, 3);
        wr(12'h008, 32'h0000_0000);
        rd(12'h008, a, b); chk("R2 ctrl clear", a, 0); chk("R11 ctrl frozen", b, 3);

        // R3 R4 R5 R7 sweep of load values
        for (int L = 1; L <= 7; L++) begin
            do_reset();
            wr(12'h008, 32'h1);
            wr(12'h000, 32'(L));
            rd(12'h000, a, b); chk("R3 load value", a, 32'(L));
            rd(12'h004, a, b); chk("R3 count loaded", a, 32'(L));
            tick(L - 1);
            rd(12'h004, a, b); chk("R4 count before expiry", a, 1);
            rd(12'h010, a, b); chk("R5 ris before expiry", a, 0);
            tick(1);
            rd(12'h004, a, b); chk("R5 count at expiry", a, 0);
            rd(12'h010, a, b); chk("R5 ris after expiry", a, 1);
            chk("R8 irq", {31'b0, irq0}, 1);
            tick(1);
            rd(12'h004, a, b); chk("R5 reload", a, 32'(L));
            wr(12'h00C, 32'hDEAD_0000 ^ 32'(L));
            rd(12'h010, a, b); chk("R7 ris cleared", a, 0);
            rd(12'h004, a, b); chk("R7 count reloaded", a, 32'(L));
            chk("R7 irq low", {31'b0, irq0}, 0);
        end

        // R6 second expiry, R8 mask sweep
        do_reset();
        wr(12'h000, 32'd3);
        tick(4);
        rd(12'h010, a, b); chk("R6 armed", a, 1);
        tick(2);
        rd(12'h004, a, b); chk("R6 one before second", a, 1);
        chk("R6 no early rst", {31'b0, rst0}, 0);
        tick(1);
        for (int c = 0; c < 4; c++) begin
            wr(12'h008, 32'(c));
            chk("R8 irq mask", {31'b0, irq0}, 32'(c & 1));
            chk("R8 rst mask", {31'b0, rst0}, 32'((c >> 1) & 1));
            rd(12'h014, a, b); chk("R8 mis", a, 32'(c & 1));
        end
        rd(12'h004, a, b); chk("R6 halted count", a, 0);
        tick(5);
        rd(12'h004, a, b); chk("R6 stays halted", a, 0);
        wr(12'h000, 32'd9);
        tick(4);
        rd(12'h004, a, b); chk("R6 load while halted", a, 9);
        wr(12'h00C, 32'h0);
        rd(12'h010, a, b); chk("R6 clear ris in halt", a, 0);
        chk("R6 rst sticky", {31'b0, rst0}, 1);
        tick(3);
        chk("R6 rst still", {31'b0, rst0}, 1);
        rd(12'h004, a, b); chk("R6 still stopped", a, 9);

        // R9 lock
        do_reset();
        for (int k = 0; k < 4; k++) begin
            logic [31:0] v;
            v = (k == 0) ? 32'h0 : (k == 1) ? 32'h1 : (k == 2) ? (KEY ^ 32'h1) : (KEY << 1);
            wr(12'hC00, v);
            rd(12'hC00, a, b); chk("R9 locked", a, 1);
            wr(12'h000, 32'h55);
            rd(12'h000, a, b); chk("R9 load blocked", a, 32'hFFFF_FFFF);
            wr(12'h008, 32'h3);
            rd(12'h008, a, b); chk("R9 ctrl blocked", a, 0);
            wr(12'hC00, KEY);
            rd(12'hC00, a, b); chk("R9 unlocked", a, 0);
        end
        wr(12'h000, 32'h55);
        rd(12'h000, a, b); chk("R9 load after unlock", a, 32'h55);

        // R10 integration outputs, R11 absent in restricted variant
        wr(12'hF00, 32'h1);
        rd(12'hF00, a, b); chk("R10 itcr", a, 1); chk("R11 itcr absent", b, 0);
        for (int op = 0; op < 4; op++) begin
            wr(12'hF04, 32'(op));
            chk("R10 irq from itop", {31'b0, irq0}, 32'((op >> 1) & 1));
            chk("R10 rst from itop", {31'b0, rst0}, 32'(op & 1));
            chk("R11 outputs untouched", {30'b0, irq1, rst1}, 0);
        end
        wr(12'hF00, 32'h0);
        chk("R10 normal again", {30'b0, irq0, rst0}, 0);

        // R12 invalid offsets, read-only writes, static bus
        rd(12'h00C, a, b); chk("R12 clr reads 0", a, 0);
        rd(12'h100, a, b); chk("R12 unmapped", a, 0);
        rd(12'hF08, a, b); chk("R12 unmapped hi", a, 0);
        rd(12'hFCC, a, b); chk("R12 below id", a, 0);
        rd(12'hF04, a, b); chk("R12 itop reads 0", a, 0); chk("R12 itop absent", b, 0);
        rd(12'h004, a, b); r = a;
        wr(12'h004, 32'h12);
        wr(12'h010, 32'h1);
        rd(12'h004, a, b); chk("R12 count ro", a, r);
        rd(12'h010, a, b); chk("R12 ris ro", a, 0);
        chk("R12 bus static", {28'b0, rdy0, err0, rdy1, err1}, 32'b1010);

        // R13 identification words
        for (int k = 0; k < 12; k++) begin
            rd(12'(12'hFD0 + 4 * k), a, b);
            chk("R13 id word", a, {24'b0, ID_TBL[k*8 +: 8]});
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule